// File: doc/BRIEF.md
# Byte-view shared word RAM

This block holds one word-wide synchronous memory that two masters share. A small 8-bit processor sees it as byte-addressable storage. A computation engine reads and writes whole 32-bit words. Neither side owns a fixed region, so each can use any word the other leaves alone. A processor byte read picks one lane out of the stored word.

A processor byte write takes two memory slots. The first slot reads the whole word. In the slot after it, the block writes back that word with the new byte merged into the addressed lane. The processor never makes back-to-back accesses to different addresses, so the block reserves the second slot unconditionally and nothing can take it.

Arbitration is per cycle and combinational. The engine wins a contested cycle. The reserved write-back slot of a processor write cannot be taken by anyone. The processor holds its request until `p_rdy` is high.

Top module: `bview_ram`

## Requirements
- R1: A processor byte address splits as follows. Bits [1:0] select the lane, with lane 0 being word bits [7:0], lane 1 bits [15:8], lane 2 bits [23:16] and lane 3 bits [31:24]. The remaining upper bits are the word address. `p_rdata` carries the selected byte in the cycle after the cycle in which the read was accepted (`p_rdy` high).
- R2: A processor byte write changes only the addressed lane of the addressed word. The other three lanes keep their previous contents.
- R3: The cycle after a processor write is accepted is the write-back cycle. In that cycle `e_gnt` and `p_rdy` are both low, whatever is requested.
- R4: Outside a write-back cycle, an engine request is granted in the same cycle (`e_gnt` high). In that cycle `p_rdy` is low even if the processor is also requesting.
- R5: `p_rdy` is high only while `p_req` is high and the processor is being served. It stays low for every cycle in which the processor waits.
- R6: An engine write (`e_we` high with `e_gnt`) replaces the whole word. An engine read returns the stored word on `e_rdata` in the cycle after the grant. This includes words built by processor byte writes and words that the processor then reads back byte by byte.
- R7: A processor read of an address accepted in the cycle right after the write-back of that address returns the newly written byte.
- R8: While `rst_n` is low, `p_rdy` and `e_gnt` are low. The first cycle after reset has no write-back pending, so an uncontested processor request is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | 1 | Processor request, held until p_rdy |
| p_we | input | 1 | Processor write (1) or read (0) |
| p_addr | input | WORD_AW+2 | Processor byte address |
| p_wdata | input | 8 | Processor write byte |
| p_rdata | output | 8 | Processor read byte, valid the cycle after acceptance |
| p_rdy | output | 1 | Processor request accepted this cycle |
| e_req | input | 1 | Engine request |
| e_we | input | 1 | Engine write (1) or read (0) |
| e_addr | input | WORD_AW | Engine word address |
| e_wdata | input | 32 | Engine write word |
| e_rdata | output | 32 | Engine read word, valid the cycle after grant |
| e_gnt | output | 1 | Engine granted this cycle |

## Verification
Two collisions can land in the same cycle. The first is an engine request against a fresh processor request. The second is an engine or processor request against the reserved write-back slot of a processor write. The bench provokes the first by raising both requests together. It expects `e_gnt` high and `p_rdy` low, and it expects the processor to be served once the engine drops its request. It provokes the second in every write-back cycle of a full byte-write sweep by raising both requests at once. It judges that cycle by both grants staying low, and then by the word contents the engine reads back and the bytes the processor reads back.

// File: rtl/bview_pkg.sv
package bview_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int LSEL_W = $clog2(LANES);
  localparam int WORD_W = LANE_W * LANES;

  function automatic logic [LANE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic [LSEL_W-1:0] sel);
    return w[sel*LANE_W +: LANE_W];
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] w,
                                                   input logic [LSEL_W-1:0] sel,
                                                   input logic [LANE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    for (int i = 0; i < LANES; i++)
      if (LSEL_W'(i) == sel) r[i*LANE_W +: LANE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/bview_mem.sv
module bview_mem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    q <= store[addr];
    if (we) store[addr] <= wdata;
  end
endmodule

// File: rtl/bview_arb.sv
module bview_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic p_req,
  input  logic p_we,
  input  logic e_req,
  output logic e_gnt,
  output logic p_rdy,
  output logic p_acc_wr,
  output logic wr_phase
);
  always_comb begin
    e_gnt    = rst_n && e_req && !wr_phase;
    p_rdy    = rst_n && p_req && !e_req && !wr_phase;
    p_acc_wr = p_rdy && p_we;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_phase <= 1'b0;
    else        wr_phase <= p_acc_wr;
  end
endmodule

// File: rtl/bview_lane.sv
module bview_lane
  import bview_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  p_rdy,
  input  logic [WORD_AW+1:0]    p_addr,
  input  logic [LANE_W-1:0]     p_wdata,
  input  logic [WORD_W-1:0]     q,
  output logic [LANE_W-1:0]     p_rdata,
  output logic [WORD_W-1:0]     merged,
  output logic [WORD_AW-1:0]    pend_waddr
);
  logic [LSEL_W-1:0] lane_q;
  logic [LANE_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q     <= '0;
      byte_q     <= '0;
      pend_waddr <= '0;
    end else if (p_rdy) begin
      lane_q     <= p_addr[LSEL_W-1:0];
      byte_q     <= p_wdata;
      pend_waddr <= p_addr[WORD_AW+1:LSEL_W];
    end
  end

  always_comb begin
    p_rdata = lane_pick(q, lane_q);
    merged  = lane_merge(q, lane_q, byte_q);
  end
endmodule

// File: rtl/bview_ram.sv
module bview_ram
  import bview_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  p_req,
  input  logic                  p_we,
  input  logic [WORD_AW+1:0]    p_addr,
  input  logic [7:0]            p_wdata,
  output logic [7:0]            p_rdata,
  output logic                  p_rdy,
  input  logic                  e_req,
  input  logic                  e_we,
  input  logic [WORD_AW-1:0]    e_addr,
  input  logic [31:0]           e_wdata,
  output logic [31:0]           e_rdata,
  output logic                  e_gnt
);
  logic               p_acc_wr, wr_phase, mem_we;
  logic [WORD_AW-1:0] mem_addr, pend_waddr;
  logic [WORD_W-1:0]  mem_wdata, mem_q, merged;

  bview_arb u_arb (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .e_req(e_req),
    .e_gnt(e_gnt), .p_rdy(p_rdy), .p_acc_wr(p_acc_wr), .wr_phase(wr_phase)
  );

  bview_lane #(.WORD_AW(WORD_AW)) u_lane (
    .clk(clk), .rst_n(rst_n), .p_rdy(p_rdy), .p_addr(p_addr),
    .p_wdata(p_wdata), .q(mem_q), .p_rdata(p_rdata), .merged(merged),
    .pend_waddr(pend_waddr)
  );

  always_comb begin
    if (wr_phase)   mem_addr = pend_waddr;
    else if (e_gnt) mem_addr = e_addr;
    else            mem_addr = p_addr[WORD_AW+1:LSEL_W];
    mem_we    = wr_phase || (e_gnt && e_we);
    mem_wdata = wr_phase ? merged : e_wdata;
  end

  bview_mem #(.AW(WORD_AW), .DW(WORD_W)) u_mem (
    .clk(clk), .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .q(mem_q)
  );

  assign e_rdata = mem_q;
endmodule

// File: rtl/bview_chk.sv
module bview_chk #(
  parameter int WORD_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               p_req,
  input logic               p_rdy,
  input logic [WORD_AW+1:0] p_addr,
  input logic               e_req,
  input logic               e_gnt,
  input logic               p_acc_wr,
  input logic               wr_phase,
  input logic               mem_we,
  input logic [WORD_AW-1:0] mem_addr
);
  a_r5_rdy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    p_rdy |-> p_req);
  a_r4_engine_first: assert property (@(posedge clk) disable iff (!rst_n)
    (e_req && !wr_phase) |-> (e_gnt && !p_rdy));
  a_r3_phase_follows: assert property (@(posedge clk) disable iff (!rst_n)
    p_acc_wr |=> (wr_phase && mem_we));
  a_r3_phase_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> (!e_gnt && !p_rdy));
  a_r3_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> !wr_phase);
  a_r2_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    p_acc_wr |=> (mem_addr == $past(p_addr[WORD_AW+1:2])));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({e_gnt, p_rdy, wr_phase}));
endmodule

bind bview_ram bview_chk #(.WORD_AW(WORD_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_rdy(p_rdy), .p_addr(p_addr),
  .e_req(e_req), .e_gnt(e_gnt), .p_acc_wr(p_acc_wr), .wr_phase(wr_phase),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/bview_ram_bench.sv
`timescale 1ns/1ps
module bview_ram_bench;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic p_req = 0, p_we = 0, e_req = 0, e_we = 0;
  logic [AW+1:0] p_addr = '0;
  logic [7:0] p_wdata = '0, p_rdata;
  logic [AW-1:0] e_addr = '0;
  logic [31:0] e_wdata = '0, e_rdata;
  logic p_rdy, e_gnt;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [NW];

  always #4 clk = ~clk;

  bview_ram #(.WORD_AW(AW)) u_bview_ram (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_rdy(p_rdy), .e_req(e_req),
    .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
    .e_gnt(e_gnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] epat(input int w);
    return 32'hA5C3_0F18 ^ (w * 32'h0103_0507);
  endfunction

  function automatic logic [7:0] bpat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic eng(input logic we, input int a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    e_req = 1; e_we = we; e_addr = AW'(a); e_wdata = d;
    #2 chk("R4 e_gnt same cycle", {31'b0, e_gnt}, 1);
    @(posedge clk); @(negedge clk);
    e_req = 0; e_we = 0;
    #1 rd = e_rdata;
  endtask

  task automatic cpu_rd(input int a, output logic [7:0] rd);
    @(negedge clk);
    p_req = 1; p_we = 0; p_addr = (AW+2)'(a);
    #2;
    while (!p_rdy) begin @(negedge clk); #2; end
    @(posedge clk); @(negedge clk);
    p_req = 0;
    #1 rd = p_rdata;
  endtask

  task automatic cpu_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    p_req = 1; p_we = 1; p_addr = (AW+2)'(a); p_wdata = d;
    #2;
    while (!p_rdy) begin @(negedge clk); #2; end
    @(posedge clk); @(negedge clk);
    // write-back cycle: both masters ask, neither may be served (R3)
    p_we = 0; e_req = 1; e_we = 0; e_addr = AW'(a >> 2);
    #2;
    chk("R3 e_gnt in write-back", {31'b0, e_gnt}, 0);
    chk("R3 p_rdy in write-back", {31'b0, p_rdy}, 0);
    #1 p_req = 0; e_req = 0;
    mdl[a >> 2][(a % 4) * 8 +: 8] = d;
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    // R8: reset holds grants low
    p_req = 1; e_req = 1;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 p_rdy in reset", {31'b0, p_rdy}, 0);
    chk("R8 e_gnt in reset", {31'b0, e_gnt}, 0);
    p_req = 0; e_req = 0;
    @(negedge clk); rst_n = 1;
    // R8: first request after reset accepted at once
    p_req = 1; p_we = 0; p_addr = '0;
    #2 chk("R8 p_rdy first cycle", {31'b0, p_rdy}, 1);
    @(negedge clk); p_req = 0;
    // R6: engine fills every word
    for (int i = 0; i < NW; i++) begin
      eng(1, i, epat(i), w);
      mdl[i] = epat(i);
    end
    // R1/R6: processor reads every byte of engine words
    for (int a = 0; a < NW * 4; a++) begin
      cpu_rd(a, b);
      chk("R1 byte lane read", {24'b0, b}, {24'b0, mdl[a >> 2][(a % 4) * 8 +: 8]});
    end
    // R2: byte writes on three lanes of each word; lane == word[1:0] kept
    for (int a = 0; a < NW * 4; a++)
      if ((a % 4) != ((a >> 2) % 4)) cpu_wr(a, bpat(a));
    for (int i = 0; i < NW; i++) begin
      eng(0, i, 32'h0, w);
      chk("R2 merged word", w, mdl[i]);
    end
    // R4/R5: contention, engine first, processor waits
    @(negedge clk);
    e_req = 1; e_we = 0; e_addr = 4'd5;
    p_req = 1; p_we = 0; p_addr = 6'd22;
    #2;
    chk("R4 e_gnt under contention", {31'b0, e_gnt}, 1);
    chk("R5 p_rdy waits", {31'b0, p_rdy}, 0);
    @(negedge clk);
    e_req = 0;
    #1 chk("R6 e_rdata after grant", e_rdata, mdl[5]);
    #1 chk("R5 p_rdy after engine leaves", {31'b0, p_rdy}, 1);
    @(negedge clk); p_req = 0;
    #1 chk("R1 p_rdata after contention", {24'b0, p_rdata}, {24'b0, mdl[5][23:16]});
    // R5: no request, no ready
    #1 chk("R5 p_rdy idle", {31'b0, p_rdy}, 0);
    // R7: read straight after write-back of same address
    for (int a = 0; a < 8; a++) begin
      cpu_wr(a * 9, 8'hF0 ^ 8'(a));
      cpu_rd(a * 9, b);
      chk("R7 read after write", {24'b0, b}, {24'b0, 8'hF0 ^ 8'(a)});
    end
    // R6: engine sees processor bytes; engine overwrite is whole-word
    eng(0, 9, 32'h0, w);
    chk("R6 engine sees bytes", w, mdl[9]);
    eng(1, 9, 32'h1234_5678, w);
    mdl[9] = 32'h1234_5678;
    for (int l = 0; l < 4; l++) begin
      cpu_rd(36 + l, b);
      chk("R6 whole-word replace", {24'b0, b}, {24'b0, mdl[9][l * 8 +: 8]});
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule